// File: doc/BRIEF.md
# Register-Reset Interrupt Controller

This block is the interrupt front end of a power-management controller. It tells a host processor, over a single active-low open-drain line, that the controller's configuration registers have gone back to their default values. Three conditions count as a register reset: the analog supply dropping below its undervoltage threshold, the host writing a software-reset request, and an external reset pin being pulled low. Each one reloads the registers to parameterised defaults and sets a sticky reset flag. A second maskable flag records a generic event. Both flags share the interrupt line.

After power-on, and after every later reset cause, a configuration-load window of `LOAD_CYCLES` clocks runs. During this window the line stays released, the block reports itself busy, and register writes are dropped. When the window closes, an unmasked reset flag pulls the line low. The host can therefore treat the falling edge as "ready to be configured". The host clears flags by writing ones to the status register. The asynchronous undervoltage and pin inputs pass through a synchroniser of `SYNC_STAGES` flops.

Register map (2-bit address, 8-bit data): address 0 is the control register, where writing 1 to bit 0 requests a software reset. Address 1 is status, with bit 0 the reset flag and bit 1 the event flag, both cleared by writing 1. Address 2 is the mask register, with bit 0 masking the reset flag and bit 1 masking the event flag; 1 means masked. Address 3 is read-only, with bit 0 the busy flag. Unused bits read 0.

Top module: `rstirq_ctrl`

## Requirements
- R1: While `rst_n` is low, and straight after it, the block reports busy, status reads 0x01, mask reads `MASK_DEFAULT`, and `int_pull_low` is 0.
- R2: Busy stays 1 for exactly `LOAD_CYCLES` observed cycles after the last reset cause and then drops to 0. `int_pull_low` is 0 throughout that window.
- R3: Writes to any address while busy are ignored: the mask, the status flags and the software-reset request all stay unchanged.
- R4: When not busy, `int_pull_low` is 1 exactly when some status bit is 1 and its mask bit (address 2) is 0.
- R5: Writing 1 to a status bit at address 1 clears it on the next clock. Writing 0 leaves it unchanged.
- R6: Writing 1 to bit 0 of address 0 while not busy reloads the mask to `MASK_DEFAULT`, sets status to 0x01 and restarts the load window.
- R7: A high `uv_in` or a low `ext_rst_n_in` acts like R6 after `SYNC_STAGES` + 1 clocks. While the condition is held, the window keeps restarting.
- R8: A set (an `evt_in` pulse, or a reset cause) and a write-one-to-clear of the same flag in the same cycle leave the flag set.
- R9: While one unmasked flag is pending, a new event leaves `int_pull_low` at 1 with no edge.
- R10: Address 3 bit 0 reads the busy flag. Reads are combinational from `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| uv_in | input | 1 | Supply undervoltage indication, active high, asynchronous |
| ext_rst_n_in | input | 1 | External reset pin, active low, asynchronous |
| evt_in | input | 1 | Generic event pulse, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data |
| int_pull_low | output | 1 | 1 = pull the open-drain interrupt pad low |

## Verification
Two functions can land in the same cycle: the setting of a flag, and the host's write-one-to-clear of that flag. The bench provokes this in two ways. It raises `evt_in` in the cycle that carries a clear of the event bit. It also times an undervoltage pulse so that its synchronised edge reaches the block in the cycle of a clear of the reset bit. In both cases the flag must read back as set, and the per-cycle reference model must agree on every cycle around the collision.

// File: rtl/rstirq_pkg.sv
// Package: shared constants and the register address encoding for the
// register-reset interrupt controller.
package rstirq_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int SRC_N   = 2;   // number of status flags
    localparam int SRC_RST = 0;   // register-reset flag position
    localparam int SRC_EVT = 1;   // generic event flag position

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 2'd0,
        A_STATUS = 2'd1,
        A_MASK   = 2'd2,
        A_BUSY   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/rstirq_sync.sv
// Module: multi-stage synchroniser for asynchronous level inputs.
// Assumes inputs are slow levels; each bit is synchronised on its own.
// On reset every stage loads RST_VAL (the inactive level of each input).
module rstirq_sync #(
    parameter int                 STAGES  = 2,
    parameter int                 WIDTH   = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first flop samples the raw input
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // later flops shift the sampled value along
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rstirq_load_timer.sv
// Module: configuration-load window timer.
// Busy rises on reset or on a restart request and falls after LOAD_CYCLES
// clocks with no restart. Assumes LOAD_CYCLES >= 2.
module rstirq_load_timer #(
    parameter int LOAD_CYCLES = 60000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic busy
);
    localparam int                CNT_W = (LOAD_CYCLES > 1) ? $clog2(LOAD_CYCLES) : 1;
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(LOAD_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // window counter: restart clears, terminal count ends the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b1;
        end else if (restart) begin
            cnt  <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == LAST) busy <= 1'b0;
            else             cnt  <= cnt + 1'b1;
        end
    end

    // R7: a restart request always opens a fresh window
    p_restart_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (busy && cnt == '0));
    // R2: the counter never runs past its terminal value during a window
    p_cnt_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= LAST));
    // R2: the window only closes from the terminal count, without restart
    p_close_at_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cnt) == LAST && !$past(restart)));
endmodule

// File: rtl/rstirq_regs.sv
// Module: mask and status registers with write-one-to-clear, decoding of
// the software-reset request, and the read multiplexer.
// Assumes that the write port is synchronous and that reads are combinational.
// A reload forces defaults and has priority over every other update.
module rstirq_regs
    import rstirq_pkg::*;
#(
    parameter logic [SRC_N-1:0] MASK_DEFAULT = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              busy,
    input  logic              evt_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              sw_req,
    output logic [SRC_N-1:0]  status,
    output logic [SRC_N-1:0]  mask
);
    localparam logic [SRC_N-1:0] STATUS_RELOAD = SRC_N'(1) << SRC_RST;

    logic             wr_ok;
    logic [SRC_N-1:0] w1c;
    logic [SRC_N-1:0] src_set;
    logic             mask_wr;

    // write qualification: all writes are dropped during the load window
    always_comb begin
        wr_ok   = wr_en && !busy;
        sw_req  = wr_ok && (wr_addr == A_CTRL) && wr_data[0];
        mask_wr = wr_ok && (wr_addr == A_MASK);
        w1c     = (wr_ok && (wr_addr == A_STATUS)) ? wr_data[SRC_N-1:0] : '0;
        src_set = '0;
        src_set[SRC_EVT] = evt_in;
    end

    // status flags: reload > set > clear, per flag
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            status <= STATUS_RELOAD;
        end else begin
            for (int b = 0; b < SRC_N; b++) begin
                if (src_set[b])  status[b] <= 1'b1;
                else if (w1c[b]) status[b] <= 1'b0;
            end
        end
    end

    // mask register: reload restores defaults, otherwise host-written
    always_ff @(posedge clk) begin
        if (!rst_n || reload) mask <= MASK_DEFAULT;
        else if (mask_wr)     mask <= wr_data[SRC_N-1:0];
    end

    // read multiplexer
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_STATUS: rd_data[SRC_N-1:0] = status;
            A_MASK:   rd_data[SRC_N-1:0] = mask;
            A_BUSY:   rd_data[0]         = busy;
            default:  rd_data            = '0;
        endcase
    end

    // R6: a reload leaves the reset flag set and the mask at its default
    p_reload_defaults_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (status[SRC_RST] && mask == MASK_DEFAULT));
    // R8: an event wins over a same-cycle clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in && !reload) |=> status[SRC_EVT]);
    // R3: the mask cannot change inside the load window except by reload
    p_mask_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !reload) |=> $stable(mask));
    // R3: status flags can only drop when a write was possible
    p_no_clear_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !reload) |=> !$fell(status[SRC_RST]));
endmodule

// File: rtl/rstirq_ctrl.sv
// Module: register-reset interrupt controller (top).
// Synchronises the asynchronous reset causes, merges them with the
// software request into one reload/restart, and drives the open-drain
// interrupt pad enable from the unmasked pending flags outside the window.
module rstirq_ctrl
    import rstirq_pkg::*;
#(
    parameter int               LOAD_CYCLES  = 60000,
    parameter int               SYNC_STAGES  = 2,
    parameter logic [SRC_N-1:0] MASK_DEFAULT = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uv_in,
    input  logic              ext_rst_n_in,
    input  logic              evt_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              int_pull_low
);
    logic [1:0]       async_s;
    logic             uv_s;
    logic             ext_n_s;
    logic             sw_req;
    logic             cause;
    logic             busy;
    logic [SRC_N-1:0] status;
    logic [SRC_N-1:0] mask;

    rstirq_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (2),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ext_rst_n_in, uv_in}),
        .q     (async_s)
    );

    // reset-cause merge: any source reloads defaults and restarts the window
    always_comb begin
        uv_s    = async_s[0];
        ext_n_s = async_s[1];
        cause   = uv_s || !ext_n_s || sw_req;
    end

    rstirq_load_timer #(
        .LOAD_CYCLES (LOAD_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cause),
        .busy    (busy)
    );

    rstirq_regs #(
        .MASK_DEFAULT (MASK_DEFAULT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (cause),
        .busy    (busy),
        .evt_in  (evt_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .sw_req  (sw_req),
        .status  (status),
        .mask    (mask)
    );

    // pad enable: OR of unmasked pending flags, gated off during the window
    assign int_pull_low = !busy && |(status & ~mask);

    // R7: a synchronised undervoltage level reaches the timer as a busy window
    p_uv_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> busy);
    // R9: with an unmasked flag still pending and no window, the line stays low
    p_pending_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_pull_low && evt_in && !mask[SRC_EVT] && !cause) |=> int_pull_low);
endmodule

// File: tb/rstirq_ctrl_tb.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks for each requirement.
module rstirq_ctrl_tb;
    localparam int       L    = 20;
    localparam int       SYNC = 2;
    localparam bit [1:0] MDEF = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uv_in = 1'b0;
    logic       ext_rst_n_in = 1'b1;
    logic       evt_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       int_pull_low;

    int checks = 0;
    int errors = 0;

    rstirq_ctrl #(.LOAD_CYCLES(L), .SYNC_STAGES(SYNC), .MASK_DEFAULT(MDEF)) u_dut (
        .clk(clk), .rst_n(rst_n), .uv_in(uv_in), .ext_rst_n_in(ext_rst_n_in),
        .evt_in(evt_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .int_pull_low(int_pull_low)
    );

    always #10 clk = ~clk;   // 50 MHz

    // ---------------- reference model ----------------
    bit       m_busy;
    int       m_cnt;
    bit [1:0] m_mask;
    bit [1:0] m_stat;
    bit       uvq[$];
    bit       exq[$];

    function automatic bit [7:0] m_read(input bit [1:0] a);
        case (a)
            2'd1:    return {6'b0, m_stat};
            2'd2:    return {6'b0, m_mask};
            2'd3:    return {7'b0, m_busy};
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit m_pull();
        return !m_busy && ((m_stat & ~m_mask) != 2'b00);
    endfunction

    always @(posedge clk) begin
        bit uvs, exs, wok, sw, cause;
        bit [1:0] clr;
        if (!rst_n) begin
            m_busy = 1; m_cnt = 0; m_mask = MDEF; m_stat = 2'b01;
            uvq.delete(); exq.delete();
            for (int i = 0; i < SYNC; i++) begin uvq.push_back(1'b0); exq.push_back(1'b1); end
        end else begin
            uvs   = uvq[0];
            exs   = exq[0];
            wok   = wr_en && !m_busy;
            sw    = wok && wr_addr == 2'd0 && wr_data[0];
            cause = uvs || !exs || sw;
            clr   = (wok && wr_addr == 2'd1) ? wr_data[1:0] : 2'b00;
            if (cause) begin
                m_busy = 1; m_cnt = 0; m_mask = MDEF; m_stat = 2'b01;
            end else begin
                if (m_busy) begin
                    if (m_cnt == L - 1) m_busy = 0;
                    else m_cnt++;
                end
                m_stat[0] = m_stat[0] & ~clr[0];
                m_stat[1] = evt_in | (m_stat[1] & ~clr[1]);
                if (wok && wr_addr == 2'd2) m_mask = wr_data[1:0];
            end
            void'(uvq.pop_front()); uvq.push_back(uv_in);
            void'(exq.pop_front()); exq.push_back(ext_rst_n_in);
        end
        #5;
        checks++;
        if (int_pull_low !== m_pull()) begin
            errors++;
            $display("FAIL R4 model: int_pull_low actual %0b expected %0b at %0t", int_pull_low, m_pull(), $time);
        end
        checks++;
        if (rd_data !== m_read(rd_addr)) begin
            errors++;
            $display("FAIL R10 model: rd_data[%0d] actual %02h expected %02h at %0t", rd_addr, rd_data, m_read(rd_addr), $time);
        end
    end

    // ---------------- helpers ----------------
    task automatic cyc();
        @(negedge clk);
        wr_en = 1'b0; evt_in = 1'b0; wr_data = '0; wr_addr = '0;
        rd_addr = rd_addr + 2'd1;
    endtask

    task automatic wr(input bit [1:0] a, input bit [7:0] d);
        cyc();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input bit [1:0] a, input bit [7:0] exp);
        rd_addr = a; #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (n < 1000) begin
            rd_addr = 2'd3; #1;
            if (rd_data[0] !== 1'b1) break;
            n++;
            cyc();
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd_chk("R1 busy", 2'd3, 8'h01);
        rd_chk("R1 status", 2'd1, 8'h01);
        rd_chk("R1 mask", 2'd2, {6'b0, MDEF});
        chk("R1 pull", int_pull_low, 0);
        rst_n = 1'b1;
        // R3: writes in the window are ignored
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h03);
        wr(2'd0, 8'h01);
        cyc();
        rd_chk("R3 mask", 2'd2, {6'b0, MDEF});
        rd_chk("R3 status", 2'd1, 8'h01);
        chk("R2 pull in window", int_pull_low, 0);
        // R2: window length (4 observed cycles already spent)
        count_busy(n);
        chk("R2 window length", n + 4, L);
        chk("R4 pull after window", int_pull_low, 1);
        rd_chk("R10 busy low", 2'd3, 8'h00);
        // R9: masked event does not disturb the line
        cyc(); evt_in = 1'b1;
        cyc();
        rd_chk("R9 status", 2'd1, 8'h03);
        chk("R9 pull", int_pull_low, 1);
        // R5: clear reset flag
        wr(2'd1, 8'h01);
        cyc();
        rd_chk("R5 clear", 2'd1, 8'h02);
        chk("R4 masked evt", int_pull_low, 0);
        wr(2'd1, 8'h00);
        cyc();
        rd_chk("R5 zero write", 2'd1, 8'h02);
        // R4: unmask the event
        wr(2'd2, 8'h00);
        cyc();
        chk("R4 unmasked evt", int_pull_low, 1);
        // R9: new event while pending
        cyc(); evt_in = 1'b1;
        cyc();
        chk("R9 no edge", int_pull_low, 1);
        // R8: set and clear together
        wr(2'd1, 8'h02); evt_in = 1'b1;
        cyc();
        rd_chk("R8 evt set wins", 2'd1, 8'h02);
        wr(2'd1, 8'h02);
        cyc();
        rd_chk("R5 evt clear", 2'd1, 8'h00);
        chk("R4 nothing pending", int_pull_low, 0);
        // R6: software reset
        wr(2'd0, 8'h01);
        cyc();
        rd_chk("R6 mask reload", 2'd2, {6'b0, MDEF});
        rd_chk("R6 status", 2'd1, 8'h01);
        count_busy(n);
        chk("R6 window length", n, L);
        wr(2'd1, 8'h01);
        cyc();
        rd_chk("R5 rst clear", 2'd1, 8'h00);
        // R8/R7: undervoltage arrives with a clear of the reset flag
        uv_in = 1'b1;
        cyc(); uv_in = 1'b0;
        cyc();
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h01;
        cyc();
        rd_chk("R8 uv set wins", 2'd1, 8'h01);
        count_busy(n);
        chk("R7 uv window", n, L);
        // R7: held external reset extends the window
        ext_rst_n_in = 1'b0;
        repeat (6) cyc();
        ext_rst_n_in = 1'b1;
        count_busy(n);
        chk("R7 ext held window", n, L + 2);
        chk("R7 pull after ext", int_pull_low, 1);
        repeat (3) cyc();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule